// File: doc/BRIEF.md
# Recursive Trapezoidal Pulse-Height Shaper

This block turns a stream of digitized preamplifier samples into pulse energies. Each accepted sample updates one running accumulator by an increment built from four taps of a sample history. The taps are the newest sample, the sample m positions back, the sample m+k positions back and the sample 2m+k positions back. The accumulated value traces a trapezoid for every step-like pulse. Its rising and falling ramps last m samples and its flat top lasts k+1 samples. Its height is m times the step amplitude. The work per sample is constant, whatever the values of m and k.

A trigger strobe, given together with a sample, starts a capture. The filter value is taken m+floor(k/2) samples after the trigger sample, which places it on the flat top for k of 2 or more. It is reported as an energy with a one-cycle valid pulse. A second trigger that comes while a capture is still pending marks the event as pile-up: no energy is reported, and a one-cycle pile-up pulse is raised. The rise and flat lengths come from input ports. Writing a new value to either one flushes the history and the accumulator.

Top module: `trap_energy_shaper`

## Requirements
- R1: While reset is applied, trap_out is 0 and trap_valid, energy_valid and pileup are low.
- R2: Each sample accepted with smp_valid high updates trap_out on the next cycle. The new value is the sum of the m newest samples (two's complement smp_data) minus the sum of the m samples that end m+k positions before the newest. Samples received before the most recent clear count as zero. trap_valid is high in that next cycle.
- R3: A cycle with smp_valid low does not advance the history and does not change trap_out, unless a clear happens (R6). trap_valid is low in the following cycle.
- R4: For a step of amplitude A out of an all-zero history, trap_out after the j-th sample of the step (j from 0) equals min(j+1,m)*A - clamp(j-m-k+1, 0, m)*A. That is a ramp over m samples and a flat top of m*A that lasts k+1 samples.
- R5: The effective m is rise_len clamped to the range 1..M_MAX, with 0 read as 1. The effective k is flat_len clamped to 0..K_MAX.
- R6: When the effective m or k differs from the value in use, the block clears the history and the accumulator at the next edge, so trap_out reads 0 in the following cycle. The sample of that cycle is dropped. Any pending capture ends with neither an energy nor a pile-up.
- R7: A trigger accepted with a sample starts a capture, and that sample is position 0. After the sample at position m+floor(k/2) is accepted, energy_valid is high for exactly one cycle. In that cycle energy equals trap_out.
- R8: A trigger accepted while a capture is pending raises pileup for one cycle. This includes a trigger on the capture sample itself. No energy is reported, the capture is dropped, and the trigger that caused the pile-up starts no new capture.
- R9: A trigger in a cycle with smp_valid low is ignored. It neither starts a capture nor causes a pile-up.
- R10: trap_out is DATA_W+clog2(M_MAX)+2 bits wide and never wraps. Full-scale positive and negative sample runs give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Two's complement sample |
| rise_len | input | clog2(M_MAX+1) | Requested ramp length m |
| flat_len | input | clog2(K_MAX+1) | Requested flat-top length k |
| trig | input | 1 | Trigger strobe, accepted only with smp_valid |
| trap_out | output | ACC_W | Filter output, two's complement |
| trap_valid | output | 1 | trap_out was updated by a sample |
| energy | output | ACC_W | Captured pulse height |
| energy_valid | output | 1 | One-cycle energy strobe |
| pileup | output | 1 | One-cycle pile-up strobe |

## Verification
Two functions can claim the same sample: the end of a capture and the arrival of a second trigger. The bench forces this case on purpose. It starts a capture and feeds exactly m+floor(k/2) more samples, with a trigger on the last one. The required result is a pile-up pulse, no energy strobe, and no new capture afterwards. The random phase, with triggers about one sample in sixteen, hits the same overlap by chance. A reference model computes the direct windowed sums and judges every cycle. A second overlap, a length change while a capture is pending, is provoked directly and must end silently.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic {
      CAP_IDLE,
      CAP_WAIT
   } cap_state_e;

   function automatic int clamp_len(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/trap_delay_line.sv
module trap_delay_line #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 48,
   parameter int IDX_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     shift,
   input  logic signed [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]         idx_a,
   input  logic [IDX_W-1:0]         idx_b,
   input  logic [IDX_W-1:0]         idx_c,
   output logic signed [DATA_W-1:0] tap_a,
   output logic signed [DATA_W-1:0] tap_b,
   output logic signed [DATA_W-1:0] tap_c
);

   logic signed [DATA_W-1:0] stg [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n || clr) stg[i] <= '0;
            else if (shift)    stg[i] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n || clr) stg[i] <= '0;
            else if (shift)    stg[i] <= stg[i-1];
         end
      end
   end

   assign tap_a = stg[idx_a];
   assign tap_b = stg[idx_b];
   assign tap_c = stg[idx_c];

endmodule

// File: rtl/trap_accum.sv
module trap_accum #(
   parameter int DATA_W    = 12,
   parameter int ACC_W     = 18,
   parameter bit PAIR_SUMS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] x_now,
   input  logic signed [DATA_W-1:0] x_m,
   input  logic signed [DATA_W-1:0] x_mk,
   input  logic signed [DATA_W-1:0] x_2mk,
   output logic signed [ACC_W-1:0]  acc,
   output logic signed [ACC_W-1:0]  acc_nxt
);

   logic signed [ACC_W-1:0] incr;

   if (PAIR_SUMS) begin : g_pair
      logic signed [ACC_W-1:0] pos_sum;
      logic signed [ACC_W-1:0] neg_sum;
      assign pos_sum = ACC_W'(x_now) + ACC_W'(x_2mk);
      assign neg_sum = ACC_W'(x_m) + ACC_W'(x_mk);
      assign incr    = pos_sum - neg_sum;
   end else begin : g_chain
      assign incr = ACC_W'(x_now) - ACC_W'(x_m) - ACC_W'(x_mk) + ACC_W'(x_2mk);
   end

   assign acc_nxt = acc + incr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc <= '0;
      else if (en)       acc <= acc_nxt;
   end

endmodule

// File: rtl/trap_capture.sv
module trap_capture
   import trap_pkg::*;
#(
   parameter int ACC_W = 18,
   parameter int CNT_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    smp_ok,
   input  logic                    trig,
   input  logic [CNT_W-1:0]        dly,
   input  logic signed [ACC_W-1:0] acc_nxt,
   output logic signed [ACC_W-1:0] energy,
   output logic                    energy_valid,
   output logic                    pileup
);

   cap_state_e       st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= CAP_IDLE;
         cnt          <= '0;
         energy       <= '0;
         energy_valid <= 1'b0;
         pileup       <= 1'b0;
      end else begin
         energy_valid <= 1'b0;
         pileup       <= 1'b0;
         if (clr) begin
            st <= CAP_IDLE;
         end else if (smp_ok) begin
            case (st)
               CAP_IDLE: begin
                  if (trig) begin
                     st  <= CAP_WAIT;
                     cnt <= dly;
                  end
               end
               CAP_WAIT: begin
                  if (trig) begin
                     pileup <= 1'b1;
                     st     <= CAP_IDLE;
                  end else if (cnt == CNT_W'(1)) begin
                     energy       <= acc_nxt;
                     energy_valid <= 1'b1;
                     st           <= CAP_IDLE;
                  end else begin
                     cnt <= cnt - CNT_W'(1);
                  end
               end
               default: st <= CAP_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/trap_energy_shaper.sv
module trap_energy_shaper
   import trap_pkg::*;
#(
   parameter  int DATA_W    = 12,
   parameter  int M_MAX     = 16,
   parameter  int K_MAX     = 16,
   parameter  bit PAIR_SUMS = 1'b1,
   localparam int M_W       = $clog2(M_MAX + 1),
   localparam int K_W       = $clog2(K_MAX + 1),
   localparam int ACC_W     = DATA_W + $clog2(M_MAX) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [M_W-1:0]    rise_len,
   input  logic [K_W-1:0]    flat_len,
   input  logic              trig,
   output logic [ACC_W-1:0]  trap_out,
   output logic              trap_valid,
   output logic [ACC_W-1:0]  energy,
   output logic              energy_valid,
   output logic              pileup
);

   localparam int DEPTH = 2 * M_MAX + K_MAX;
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(M_MAX + K_MAX / 2 + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (M_MAX < 1) begin : g_bad_m_max
      $error("M_MAX must be at least 1");
   end
   if (K_MAX < 0) begin : g_bad_k_max
      $error("K_MAX must not be negative");
   end

   logic [M_W-1:0]          m_sat, m_q;
   logic [K_W-1:0]          k_sat, k_q;
   logic                    cfg_chg;
   logic                    shift;
   logic [IDX_W-1:0]        idx_m, idx_mk, idx_2mk;
   logic [CNT_W-1:0]        cap_dly;
   logic signed [DATA_W-1:0] x_m, x_mk, x_2mk;
   logic signed [ACC_W-1:0] acc, acc_nxt, cap_val;

   assign m_sat   = M_W'(clamp_len(int'(rise_len), 1, M_MAX));
   assign k_sat   = K_W'(clamp_len(int'(flat_len), 0, K_MAX));
   assign cfg_chg = (m_sat != m_q) || (k_sat != k_q);
   assign shift   = smp_valid && !cfg_chg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q        <= M_W'(1);
         k_q        <= '0;
         trap_valid <= 1'b0;
      end else begin
         m_q        <= m_sat;
         k_q        <= k_sat;
         trap_valid <= shift;
      end
   end

   assign idx_m   = IDX_W'(int'(m_q) - 1);
   assign idx_mk  = IDX_W'(int'(m_q) + int'(k_q) - 1);
   assign idx_2mk = IDX_W'(2 * int'(m_q) + int'(k_q) - 1);
   assign cap_dly = CNT_W'(int'(m_q) + int'(k_q) / 2);

   trap_delay_line #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cfg_chg),
      .shift(shift),
      .din  (smp_data),
      .idx_a(idx_m),
      .idx_b(idx_mk),
      .idx_c(idx_2mk),
      .tap_a(x_m),
      .tap_b(x_mk),
      .tap_c(x_2mk)
   );

   trap_accum #(
      .DATA_W   (DATA_W),
      .ACC_W    (ACC_W),
      .PAIR_SUMS(PAIR_SUMS)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cfg_chg),
      .en     (shift),
      .x_now  (smp_data),
      .x_m    (x_m),
      .x_mk   (x_mk),
      .x_2mk  (x_2mk),
      .acc    (acc),
      .acc_nxt(acc_nxt)
   );

   trap_capture #(
      .ACC_W(ACC_W),
      .CNT_W(CNT_W)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (cfg_chg),
      .smp_ok      (shift),
      .trig        (trig),
      .dly         (cap_dly),
      .acc_nxt     (acc_nxt),
      .energy      (cap_val),
      .energy_valid(energy_valid),
      .pileup      (pileup)
   );

   assign trap_out = acc;
   assign energy   = cap_val;

endmodule

// File: rtl/trap_energy_shaper_chk.sv
module trap_energy_shaper_chk #(
   parameter int DATA_W = 12,
   parameter int M_MAX  = 16,
   parameter int ACC_W  = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             trig,
   input logic [ACC_W-1:0] trap_out,
   input logic             trap_valid,
   input logic [ACC_W-1:0] energy,
   input logic             energy_valid,
   input logic             pileup
);

   localparam longint BOUND = longint'(M_MAX) * (longint'(1) <<< DATA_W);

   AST_ENERGY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      energy_valid |-> (energy == trap_out)); // R7
   AST_ENERGY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      energy_valid |=> !energy_valid); // R7
   AST_PILEUP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      pileup |-> !energy_valid); // R8
   AST_PILEUP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pileup |=> !pileup); // R8
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !trap_valid); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(trap_out) || trap_out == '0)); // R3
   AST_TRIG_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !smp_valid) |=> !pileup); // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'($signed(trap_out)) <= BOUND) && (longint'($signed(trap_out)) >= -BOUND)); // R10

endmodule

bind trap_energy_shaper trap_energy_shaper_chk #(
   .DATA_W(DATA_W),
   .M_MAX (M_MAX),
   .ACC_W (ACC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .trig        (trig),
   .trap_out    (trap_out),
   .trap_valid  (trap_valid),
   .energy      (energy),
   .energy_valid(energy_valid),
   .pileup      (pileup)
);

// File: tb/sim_trap_energy_shaper.sv
module sim_trap_energy_shaper;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 12;
   localparam int M_MAX  = 16;
   localparam int K_MAX  = 16;
   localparam int M_W    = $clog2(M_MAX + 1);
   localparam int K_W    = $clog2(K_MAX + 1);
   localparam int ACC_W  = DATA_W + $clog2(M_MAX) + 2;
   localparam int DEPTH  = 2 * M_MAX + K_MAX;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_valid = 1'b0;
   logic [DATA_W-1:0] smp_data = '0;
   logic [M_W-1:0]    rise_len = M_W'(4);
   logic [K_W-1:0]    flat_len = K_W'(2);
   logic              trig = 1'b0;
   logic [ACC_W-1:0]  trap_out;
   logic              trap_valid;
   logic [ACC_W-1:0]  energy;
   logic              energy_valid;
   logic              pileup;

   int     checks = 0;
   int     errors = 0;
   bit     done = 1'b0;
   longint xb [DEPTH];
   int     mb = 4;
   int     kb = 2;
   longint tb_trap = 0;
   bit     busy = 1'b0;
   int     remain = 0;
   bit     last_ev = 1'b0;
   longint last_e = 0;

   trap_energy_shaper #(
      .DATA_W(DATA_W),
      .M_MAX (M_MAX),
      .K_MAX (K_MAX)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .smp_data    (smp_data),
      .rise_len    (rise_len),
      .flat_len    (flat_len),
      .trig        (trig),
      .trap_out    (trap_out),
      .trap_valid  (trap_valid),
      .energy      (energy),
      .energy_valid(energy_valid),
      .pileup      (pileup)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int sat_m(input int v);
      return (v < 1) ? 1 : ((v > M_MAX) ? M_MAX : v);
   endfunction

   function automatic int sat_k(input int v);
      return (v > K_MAX) ? K_MAX : v;
   endfunction

   function automatic longint model_trap();
      longint s = 0;
      for (int i = 0; i < mb; i++) s += xb[i];
      for (int i = mb + kb; i < 2 * mb + kb; i++) s -= xb[i];
      return s;
   endfunction

   function automatic longint step_ref(input int j, input int m, input int k, input longint a);
      int up = (j + 1 < m) ? j + 1 : m;
      int dn = j - m - k + 1;
      if (dn < 0) dn = 0;
      if (dn > m) dn = m;
      return longint'(up) * a - longint'(dn) * a;
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < DEPTH; i++) xb[i] = 0;
      tb_trap = 0;
      busy    = 1'b0;
      remain  = 0;
   endtask

   task automatic step(input bit v, input longint d, input bit t);
      bit     exp_ev = 1'b0;
      bit     exp_pu = 1'b0;
      longint exp_e  = 0;
      @(negedge clk);
      smp_valid = v;
      smp_data  = DATA_W'(d);
      trig      = t;
      @(posedge clk);
      #1;
      if (v) begin
         for (int i = DEPTH - 1; i > 0; i--) xb[i] = xb[i-1];
         xb[0]   = d;
         tb_trap = model_trap();
         if (t) begin
            if (busy) begin
               exp_pu = 1'b1;
               busy   = 1'b0;
            end else begin
               busy   = 1'b1;
               remain = mb + kb / 2;
            end
         end else if (busy) begin
            remain--;
            if (remain == 0) begin
               busy   = 1'b0;
               exp_ev = 1'b1;
               exp_e  = tb_trap;
            end
         end
      end
      check(v ? "R2" : "R3", "trap_out", longint'($signed(trap_out)), tb_trap);
      check(v ? "R2" : "R3", "trap_valid", longint'(trap_valid), longint'(v));
      check("R7", "energy_valid", longint'(energy_valid), longint'(exp_ev));
      check((t && !v) ? "R9" : "R8", "pileup", longint'(pileup), longint'(exp_pu));
      if (exp_ev) check("R7", "energy", longint'($signed(energy)), exp_e);
      last_ev = energy_valid;
      last_e  = longint'($signed(energy));
   endtask

   task automatic set_cfg(input int m, input int k);
      int nm = sat_m(m);
      int nk = sat_k(k);
      @(negedge clk);
      rise_len  = M_W'(m);
      flat_len  = K_W'(k);
      smp_valid = 1'b0;
      trig      = 1'b0;
      if (nm != mb || nk != kb) model_clear();
      mb = nm;
      kb = nk;
      @(posedge clk);
      #1;
      check("R6", "trap_out after length write", longint'($signed(trap_out)), tb_trap);
      check("R6", "energy_valid after length write", longint'(energy_valid), 0);
      check("R6", "pileup after length write", longint'(pileup), 0);
   endtask

   function automatic longint rnd_sample();
      return longint'(int'($urandom_range(4095)) - 2048);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      model_clear();
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1", "trap_out in reset", longint'(trap_out), 0);
      check("R1", "trap_valid in reset", longint'(trap_valid), 0);
      check("R1", "energy_valid in reset", longint'(energy_valid), 0);
      check("R1", "pileup in reset", longint'(pileup), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 0, 1'b0);
      step(1'b0, 0, 1'b0);

      // R4 step response with energy on the flat top (R7)
      set_cfg(5, 0);
      set_cfg(4, 2);
      for (int j = 0; j < 12; j++) begin
         step(1'b1, 100, j == 0);
         check("R4", "step response", longint'($signed(trap_out)), step_ref(j, 4, 2, 100));
         if (j == 5) begin
            check("R7", "capture strobe at m+k/2", longint'(last_ev), 1);
            check("R7", "captured height", last_e, 400);
         end
      end

      // R8 second trigger on the capture sample itself
      set_cfg(3, 4);
      step(1'b1, 50, 1'b1);
      for (int j = 1; j <= 5; j++) step(1'b1, 50, j == 5);
      for (int j = 0; j < 8; j++) step(1'b1, 10, 1'b0);

      // R9 trigger without a sample is ignored
      step(1'b1, 20, 1'b1);
      step(1'b0, 0, 1'b1);
      step(1'b0, 0, 1'b1);
      for (int j = 0; j < 8; j++) step(1'b1, 20, 1'b0);

      // R6 length write while a capture is pending
      step(1'b1, 30, 1'b1);
      step(1'b1, 30, 1'b0);
      set_cfg(5, 0);
      for (int j = 0; j < 12; j++) step(1'b1, 30, 1'b0);

      // R5 clamping of out-of-range lengths
      set_cfg(25, 30);
      check("R5", "clamped m", longint'(mb), M_MAX);
      for (int j = 0; j < 70; j++) step(1'b1, rnd_sample(), j == 3);
      set_cfg(0, 0);
      check("R5", "zero m read as one", longint'(mb), 1);
      for (int j = 0; j < 10; j++) step(1'b1, rnd_sample(), j == 2);

      // R10 full-scale runs
      set_cfg(16, 0);
      for (int j = 0; j < 40; j++) step(1'b1, 2047, 1'b0);
      for (int j = 0; j < 60; j++) step(1'b1, -2048, 1'b0);
      for (int j = 0; j < 40; j++) step(1'b1, 2047, 1'b0);

      // random mix over several lengths
      for (int c = 0; c < 5; c++) begin
         set_cfg(int'($urandom_range(M_MAX)), int'($urandom_range(K_MAX)));
         for (int j = 0; j < 600; j++)
            step($urandom_range(3) != 0, rnd_sample(), $urandom_range(15) == 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule